// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This unit produces the effective address of a load or store, or the operand itself when the value comes straight from the instruction. A caller supplies the mode, the base and index register values, a 16-bit immediate and the current PC, then raises `start` for one cycle. Seven modes are covered: a literal operand, an absolute address taken from the instruction, base only, base plus signed immediate, base plus index register, PC plus signed immediate, and a memory-indirect mode. In the memory-indirect mode the base register points at a memory word, and that word is the final address.

The two modes that add an offset to the base can also update the base register. The offset can be applied without changing the base. It can be applied with the sum written back to the base. Or the old base can be used as the address while the sum is still written back. The write-back value and its enable come out next to the result, so the caller can feed them into its register file.

Register-based modes finish one cycle after `start`. The memory-indirect mode first issues one read on a simple request/valid port and finishes one cycle after the read data arrives. While that read is outstanding, any new `start` is dropped.

Top module: `addr_gen_unit`

## Requirements
- R1: A synchronous active-low reset clears `done`, `mem_req` and `wb_en`, and abandons any outstanding indirect read.
- R2: Mode 0 (literal) returns the sign-extended immediate on `result`, with `result_is_operand` high and `done` high in the cycle after `start`.
- R3: Mode 1 (absolute) returns the immediate zero-extended to 32 bits as the address.
- R4: Mode 2 (base only) returns `base` as the address.
- R5: Mode 3 (base plus offset) returns `base` plus the sign-extended immediate, wrapping modulo 2^32.
- R6: Mode 4 (indexed) returns `base` plus `index`, wrapping modulo 2^32.
- R7: Mode 5 (PC-relative) returns `pc` plus the sign-extended immediate.
- R8: In modes 3 and 4, update code 1 (pre-offset with write-back) gives `result` equal to the sum, with `wb_en` high and `wb_data` equal to the sum. Update code 0 or 3 leaves `wb_en` low.
- R9: In modes 3 and 4, update code 2 (post-offset) gives `result` equal to the unmodified `base`, with `wb_en` high and `wb_data` equal to base plus offset.
- R10: Mode 6 (memory indirect) raises `mem_req` in the cycle after `start`, with `mem_addr` equal to `base`. Both stay unchanged until `mem_valid`. One cycle after `mem_valid`, `done` is high, `result` equals the sampled `mem_rdata`, `mem_req` is low and `wb_en` is low.
- R11: A `start` that arrives while an indirect read is outstanding is ignored: it produces no `done` and does not change `mem_addr`.
- R12: `wb_en` is never high without `done`. The update code has no effect in modes 0, 1, 2, 5 and 6.
- R13: `done` is a single-cycle pulse for each accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one address computation |
| mode | input | 3 | Addressing mode, codes 0..6 |
| upd | input | 2 | Base update code: 0 none, 1 pre with write-back, 2 post, 3 none |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| imm | input | 16 | Immediate or absolute address field |
| pc | input | 32 | Current program counter |
| mem_req | output | 1 | Indirect read request, held until `mem_valid` |
| mem_addr | output | 32 | Address of the pointer word |
| mem_rdata | input | 32 | Read data returned by memory |
| mem_valid | input | 1 | `mem_rdata` is valid this cycle |
| done | output | 1 | Result is valid for one cycle |
| result | output | 32 | Effective address or literal operand |
| result_is_operand | output | 1 | `result` is a literal operand, not an address |
| wb_en | output | 1 | Write `wb_data` back to the base register |
| wb_data | output | 32 | Updated base value |

## Verification
A wrong sequencer state shows at the ports within one cycle. If the unit is stuck waiting, every later `start` gets no `done`. If it leaves the wait state early, `done` rises while `mem_req` is still high, or it rises with stale read data. A wrong update decode shows on the same `done` cycle as a spurious or missing `wb_en`, or as a `result` equal to the sum where the old base was expected. The table of vectors compares every output field on each `done`. The directed tests cover reset during a read, a `start` while busy, and read-data latency.

// File: rtl/agu_pkg.sv
// Package agu_pkg
// Holds the mode and update codes shared by the address generation unit.
// Assumes: the code values are fixed by the caller's decode and must not move.
package agu_pkg;

    typedef enum logic [2:0] {
        AM_LITERAL  = 3'd0,
        AM_ABSOLUTE = 3'd1,
        AM_BASE     = 3'd2,
        AM_BASE_OFS = 3'd3,
        AM_BASE_IDX = 3'd4,
        AM_PC_OFS   = 3'd5,
        AM_MEM_IND  = 3'd6
    } amode_e;

    typedef enum logic [1:0] {
        UP_NONE    = 2'd0,
        UP_PRE_WB  = 2'd1,
        UP_POST_WB = 2'd2,
        UP_RSVD    = 2'd3
    } upd_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_e;

endpackage

// File: rtl/agu_ea_calc.sv
// Module agu_ea_calc
// Purely combinational: forms the effective address, or the literal operand,
// plus the base write-back value for every single-cycle mode.
// Assumes: DATA_W >= IMM_W. All sums wrap modulo 2^DATA_W.
module agu_ea_calc
    import agu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [2:0]        mode,
    input  logic [1:0]        upd,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ea,
    output logic              is_operand,
    output logic              is_indirect,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;
    logic [DATA_W-1:0] ofs;
    logic [DATA_W-1:0] base_sum;
    logic [DATA_W-1:0] pc_sum;
    logic              updating_mode;

    // Widen the immediate field, signed and unsigned.
    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
            assign imm_zx = {{EXT_W{1'b0}}, imm};
        end else begin : g_noext
            assign imm_sx = imm[DATA_W-1:0];
            assign imm_zx = imm[DATA_W-1:0];
        end
    endgenerate

    // One shared base adder. Its second operand is the index or the immediate.
    always_comb begin
        ofs      = (mode == AM_BASE_IDX) ? index : imm_sx;
        base_sum = base + ofs;
        pc_sum   = pc + imm_sx;
    end

    // Choose the result and the base update for the requested mode.
    always_comb begin
        updating_mode = (mode == AM_BASE_OFS) || (mode == AM_BASE_IDX);
        is_operand    = (mode == AM_LITERAL);
        is_indirect   = (mode == AM_MEM_IND);
        wb_data       = base_sum;
        wb_en         = updating_mode && ((upd == UP_PRE_WB) || (upd == UP_POST_WB));
        unique case (mode)
            AM_LITERAL:  ea = imm_sx;
            AM_ABSOLUTE: ea = imm_zx;
            AM_BASE:     ea = base;
            AM_BASE_OFS,
            AM_BASE_IDX: ea = (upd == UP_POST_WB) ? base : base_sum;
            AM_PC_OFS:   ea = pc_sum;
            default:     ea = base;
        endcase
    end

endmodule

// File: rtl/agu_seq.sv
// Module agu_seq
// Sequencer and output registers. Single-cycle modes register the
// calculator's result straight away. The memory-indirect mode first runs one
// request/valid read and returns the data that comes back.
// Assumes: memory holds mem_rdata valid only in the mem_valid cycle.
// mem_valid is ignored unless a request is outstanding.
module agu_seq
    import agu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] calc_ea,
    input  logic              calc_is_operand,
    input  logic              calc_is_indirect,
    input  logic              calc_wb_en,
    input  logic [DATA_W-1:0] calc_wb_data,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_valid,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              result_is_operand,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data
);
    seq_e state;

    // Advance the sequencer and load the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state             <= SQ_IDLE;
            mem_req           <= 1'b0;
            mem_addr          <= '0;
            done              <= 1'b0;
            result            <= '0;
            result_is_operand <= 1'b0;
            wb_en             <= 1'b0;
            wb_data           <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (calc_is_indirect) begin
                            state    <= SQ_WAIT;
                            mem_req  <= 1'b1;
                            mem_addr <= base;
                        end else begin
                            done              <= 1'b1;
                            result            <= calc_ea;
                            result_is_operand <= calc_is_operand;
                            wb_en             <= calc_wb_en;
                            wb_data           <= calc_wb_data;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (mem_valid) begin
                        state             <= SQ_IDLE;
                        mem_req           <= 1'b0;
                        done              <= 1'b1;
                        result            <= mem_rdata;
                        result_is_operand <= 1'b0;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // A write-back is reported only with a completed computation.
    p_wb_needs_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // An unanswered request holds its address and stays raised.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // Read data completes the indirect access in the next cycle, with no write-back.
    p_ind_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (done && !mem_req && !wb_en));

    // A start during an outstanding read yields no completion.
    p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && start) |=> !done);

    // done never overlaps an outstanding read.
    p_req_excl_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);

endmodule

// File: rtl/addr_gen_unit.sv
// Module addr_gen_unit (top)
// Multi-mode address generation: seven addressing modes, an optional base
// update (pre-offset with write-back, or post-offset) and a one-read indirect mode.
// Assumes: the decode and register file sit outside. Inputs are sampled in
// the start cycle only, except mem_rdata/mem_valid during an indirect read.
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [1:0]        upd,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] pc,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_valid,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              result_is_operand,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_data
);
    logic [DATA_W-1:0] c_ea;
    logic              c_is_op;
    logic              c_is_ind;
    logic              c_wb_en;
    logic [DATA_W-1:0] c_wb_data;

    agu_ea_calc #(.DATA_W(DATA_W), .IMM_W(IMM_W)) calc_i (
        .mode        (mode),
        .upd         (upd),
        .base        (base),
        .index       (index),
        .imm         (imm),
        .pc          (pc),
        .ea          (c_ea),
        .is_operand  (c_is_op),
        .is_indirect (c_is_ind),
        .wb_en       (c_wb_en),
        .wb_data     (c_wb_data)
    );

    agu_seq #(.DATA_W(DATA_W)) seq_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .start             (start),
        .base              (base),
        .calc_ea           (c_ea),
        .calc_is_operand   (c_is_op),
        .calc_is_indirect  (c_is_ind),
        .calc_wb_en        (c_wb_en),
        .calc_wb_data      (c_wb_data),
        .mem_req           (mem_req),
        .mem_addr          (mem_addr),
        .mem_rdata         (mem_rdata),
        .mem_valid         (mem_valid),
        .done              (done),
        .result            (result),
        .result_is_operand (result_is_operand),
        .wb_en             (wb_en),
        .wb_data           (wb_data)
    );

    // A single-cycle start taken while idle completes in the next cycle.
    p_one_cycle_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && !done && mode != 3'd6) |=> done);

    // An update code on a mode without a base update never raises wb_en.
    p_no_wb_other_modes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && mode != 3'd3 && mode != 3'd4) |=> !wb_en);

endmodule

// File: tb/addr_gen_unit_tb.sv
`timescale 1ns/1ps
// Bench addr_gen_unit_tb_top
// Walks a table of vectors for the single-cycle modes, then runs directed
// tests for reset, the indirect read, a start while busy, and pulse length.
module addr_gen_unit_tb_top;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  upd;
        logic [31:0] base;
        logic [31:0] index;
        logic [15:0] imm;
        logic [31:0] pc;
        logic [31:0] exp_res;
        logic        exp_op;
        logic        exp_wb;
        logic [31:0] exp_wbd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R2 literal: sign-extended immediate
        '{3'd0, 2'd0, 32'h0000_1000, 32'h0, 16'hFFF0, 32'h0, 32'hFFFF_FFF0, 1'b1, 1'b0, 32'h0},
        // R3 absolute: zero-extended field
        '{3'd1, 2'd0, 32'h0, 32'h0, 16'h8004, 32'h0, 32'h0000_8004, 1'b0, 1'b0, 32'h0},
        // R4 base only
        '{3'd2, 2'd0, 32'h2000_0040, 32'h0, 16'h0000, 32'h0, 32'h2000_0040, 1'b0, 1'b0, 32'h0},
        // R5 base plus negative offset, no update
        '{3'd3, 2'd0, 32'h0000_0100, 32'h0, 16'hFFFC, 32'h0, 32'h0000_00FC, 1'b0, 1'b0, 32'h0},
        // R8 pre-offset with write-back
        '{3'd3, 2'd1, 32'h0000_0100, 32'h0, 16'h0010, 32'h0, 32'h0000_0110, 1'b0, 1'b1, 32'h0000_0110},
        // R9 post-offset
        '{3'd3, 2'd2, 32'h0000_0100, 32'h0, 16'h0010, 32'h0, 32'h0000_0100, 1'b0, 1'b1, 32'h0000_0110},
        // R6 indexed
        '{3'd4, 2'd0, 32'h0000_1000, 32'h24, 16'h0000, 32'h0, 32'h0000_1024, 1'b0, 1'b0, 32'h0},
        // R9 indexed post-offset, sum wraps
        '{3'd4, 2'd2, 32'hFFFF_FFF0, 32'h20, 16'h0000, 32'h0, 32'hFFFF_FFF0, 1'b0, 1'b1, 32'h0000_0010},
        // R7 PC-relative with negative offset
        '{3'd5, 2'd0, 32'h0, 32'h0, 16'hFF00, 32'h0000_4000, 32'h0000_3F00, 1'b0, 1'b0, 32'h0},
        // R12 update code ignored on PC-relative
        '{3'd5, 2'd1, 32'h0, 32'h0, 16'h0008, 32'h0000_0010, 32'h0000_0018, 1'b0, 1'b0, 32'h0},
        // R12 update code ignored on base only
        '{3'd2, 2'd2, 32'h0000_0500, 32'h0, 16'h0040, 32'h0, 32'h0000_0500, 1'b0, 1'b0, 32'h0},
        // R8 indexed pre-offset, negative index
        '{3'd4, 2'd1, 32'h0000_0010, 32'hFFFF_FFF8, 16'h0000, 32'h0, 32'h0000_0008, 1'b0, 1'b1, 32'h0000_0008}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  upd = '0;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [15:0] imm = '0;
    logic [31:0] pc = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        done;
    logic [31:0] result;
    logic        result_is_operand;
    logic        wb_en;
    logic [31:0] wb_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    addr_gen_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .upd(upd),
        .base(base), .index(index), .imm(imm), .pc(pc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .done(done), .result(result),
        .result_is_operand(result_is_operand), .wb_en(wb_en), .wb_data(wb_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [1:0] u,
                         input logic [31:0] b, input logic [31:0] x,
                         input logic [15:0] i, input logic [31:0] p);
        mode = m; upd = u; base = b; index = x; imm = i; pc = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "done", {31'b0, done}, 32'd0);
        chk("R1", "mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1", "wb_en", {31'b0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over the single-cycle modes
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].mode, VECS[k].upd, VECS[k].base, VECS[k].index,
                  VECS[k].imm, VECS[k].pc);
            chk("R2-R9,R12 vec", "done", {31'b0, done}, 32'd1);
            chk("R2-R9,R12 vec", "result", result, VECS[k].exp_res);
            chk("R2 vec", "is_operand", {31'b0, result_is_operand}, {31'b0, VECS[k].exp_op});
            chk("R8/R9/R12 vec", "wb_en", {31'b0, wb_en}, {31'b0, VECS[k].exp_wb});
            if (VECS[k].exp_wb)
                chk("R8/R9 vec", "wb_data", wb_data, VECS[k].exp_wbd);
            @(negedge clk);
            // R13: done falls again after one cycle
            chk("R13", "done pulse", {31'b0, done}, 32'd0);
        end

        // R13: back-to-back starts give two consecutive done pulses
        apply(3'd2, 2'd0, 32'hA, 32'h0, 16'h0, 32'h0);
        chk("R13", "b2b first", {31'b0, done}, 32'd1);
        apply(3'd2, 2'd0, 32'hB, 32'h0, 16'h0, 32'h0);
        chk("R13", "b2b second", {31'b0, done}, 32'd1);
        chk("R4", "b2b result", result, 32'hB);
        @(negedge clk);

        // R10: memory-indirect read with latency; update code set but ignored (R12)
        apply(3'd6, 2'd1, 32'h0000_3000, 32'h0, 16'h0, 32'h0);
        chk("R10", "mem_req raised", {31'b0, mem_req}, 32'd1);
        chk("R10", "mem_addr", mem_addr, 32'h0000_3000);
        chk("R10", "no early done", {31'b0, done}, 32'd0);
        // R11: start while busy is dropped
        apply(3'd3, 2'd1, 32'h0000_7777, 32'h0, 16'h0004, 32'h0);
        chk("R11", "no done while busy", {31'b0, done}, 32'd0);
        chk("R11", "mem_addr kept", mem_addr, 32'h0000_3000);
        @(negedge clk);
        chk("R11", "still no done", {31'b0, done}, 32'd0);
        chk("R10", "mem_req held", {31'b0, mem_req}, 32'd1);
        mem_valid = 1'b1;
        mem_rdata = 32'hDEAD_BEE0;
        @(negedge clk);
        mem_valid = 1'b0;
        mem_rdata = 32'h0;
        chk("R10", "done after valid", {31'b0, done}, 32'd1);
        chk("R10", "indirect result", result, 32'hDEAD_BEE0);
        chk("R10", "mem_req dropped", {31'b0, mem_req}, 32'd0);
        chk("R12", "no wb on indirect", {31'b0, wb_en}, 32'd0);
        chk("R10", "operand flag low", {31'b0, result_is_operand}, 32'd0);
        @(negedge clk);
        chk("R13", "indirect done pulse", {31'b0, done}, 32'd0);

        // R10: zero-latency-after-request case: valid in first request cycle
        apply(3'd6, 2'd0, 32'h0000_0044, 32'h0, 16'h0, 32'h0);
        mem_valid = 1'b1;
        mem_rdata = 32'h1234_5678;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R10", "fast done", {31'b0, done}, 32'd1);
        chk("R10", "fast result", result, 32'h1234_5678);
        @(negedge clk);

        // R1: reset during an outstanding read
        apply(3'd6, 2'd0, 32'h0000_0088, 32'h0, 16'h0, 32'h0);
        chk("R1", "req before reset", {31'b0, mem_req}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "req cleared", {31'b0, mem_req}, 32'd0);
        chk("R1", "done cleared", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Unit accepts work again after reset
        apply(3'd1, 2'd0, 32'h0, 32'h0, 16'h00F0, 32'h0);
        chk("R1", "usable after reset", {31'b0, done}, 32'd1);
        chk("R3", "result after reset", result, 32'h0000_00F0);
        @(negedge clk);

        finish_run();
    end

endmodule